// File: doc/BRIEF.md
# MDIO Management Master

A bus-mapped master for the two-wire PHY management interface. Each Clause 22 transaction is described by a single 32-bit command word. The word holds a start bit, a read/write select, a 5-bit PHY address, a 5-bit register address and the 16-bit value to send on a write. A write to the command offset with the start bit set launches the frame. The block then produces the management clock and drives the data line. It shows progress in a status word and, for reads, keeps the 16 bits returned by the PHY in a read-data word.

The serial clock is the system clock divided by an even ratio given as a parameter. It rests low between transactions. The data line is driven by an output with a separate enable, so it can share a bidirectional pad. Outgoing bits change on the falling edge of the serial clock. Incoming bits are taken on the rising edge.

Top module: `mdio_master_top`

## Requirements
- R1: After reset, the status word (offset 0x10) and the read-data word (offset 0x0C) read 0, and `mdc` and `mdioOe` are low. Whenever no transaction is running, `mdc` and `mdioOe` stay low.
- R2: A write to offset 0x04 with bit 0 set starts a transaction. While it runs, status bits 2:0 read 3'b001 and bits 4:3 read 2'b00. Reading 0x04 returns the last accepted command with bit 0 shown as 0.
- R3: The first 46 bit times carry, MSB first: 32 ones, start code 01, opcode 10 for a read (command bit 1 = 0) or 01 for a write (command bit 1 = 1), the PHY address from command bits 6:2, and the register address from command bits 11:7.
- R4: On a write, bit times 47 and 48 carry 1 then 0, and bit times 49 to 64 carry command bits 27:12, MSB first. `mdioOe` stays high for all 64 bit times.
- R5: On a read, `mdioOe` is high for the first 46 bit times and low for the last 18. Command bits 27:12 have no effect on the line.
- R6: On a read, the values of `mdioIn` at the rising `mdc` edges of bit times 49 to 64 are placed, first bit in bit 15, into read-data bits 15:0 when the transaction ends.
- R7: `mdc` has a period of DIV_RATIO system clocks with equal high and low halves. `mdioOut` does not change while `mdc` is high.
- R8: When a transaction ends, status reads 0x08: the busy bits are 0 and the complete bits 4:3 are 2'b01. The complete bits return to 0 as soon as a new transaction starts.
- R9: A command write made while a transaction runs is ignored. The running frame and the value read back from 0x04 are both unchanged.
- R10: A write transaction leaves the read-data word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register byte offset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data line value to drive |
| mdioOe | output | 1 | Data line drive enable |
| mdioIn | input | 1 | Data line value from the pad |

## Verification
A wrong bit counter or a wrong shift register shows at the ports within the same transaction: a misplaced field or a misplaced turnaround shows up in the bits captured on the rising serial clock, or in the point where the drive enable drops. A wrong divider shows up within one serial-clock period, as a wrong high or low time. A wrong busy or complete flag shows up in the first status read after the start, or after the end. A wrong capture path is only seen when the read-data word is read at the end of a read, so read responses use patterns that tell apart an off-by-one sample and a reversed order.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int HDR_DRIVEN = 46;
  localparam logic [7:0] OFS_CMD    = 8'h04;
  localparam logic [7:0] OFS_RDDATA = 8'h0C;
  localparam logic [7:0] OFS_STATUS = 8'h10;

  typedef struct packed {
    logic load;     // capture command and build frame
    logic shift;    // advance to next bit (falling mdc)
    logic sample;   // take mdioIn (rising mdc)
    logic finish;   // last bit done, release line
    logic capture;  // copy sampled bits to read-data word
  } mdio_strb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_RATIO = 4,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output mdio_strb_t        strb,
  output logic              busy,
  output logic              done,
  output logic              mdc,
  output logic              cmdDir,
  output logic [27:0]       cmdWord
);
  localparam int HALF  = DIV_RATIO / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF - 1);
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [27:0]      cmdReg;
  logic             mdcQ, busyQ, doneQ;
  logic             wrCmd, startReq, tick, riseEv, fallEv, lastEv;
  logic             unusedHi;

  assign unusedHi = ^busWrData[31:28];

  assign wrCmd    = busWrEn && (busAddr == ADDR_W'(OFS_CMD));
  assign startReq = wrCmd && busWrData[0] && !busyQ;
  assign tick     = busyQ && (divCnt == CNT_TOP);
  assign riseEv   = tick && !mdcQ;
  assign fallEv   = tick && mdcQ;
  assign lastEv   = fallEv && (bitCnt == BIT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      mdcQ   <= 1'b0;
    end else if (startReq) begin
      busyQ  <= 1'b1;
      doneQ  <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      mdcQ   <= 1'b0;
    end else if (busyQ) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) mdcQ <= ~mdcQ;
      if (lastEv) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end else if (fallEv) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmdReg <= '0;
    else if (wrCmd && !busyQ) cmdReg <= {busWrData[27:1], 1'b0};
  end

  always_comb begin
    strb         = '0;
    strb.load    = startReq;
    strb.shift   = fallEv && !lastEv;
    strb.sample  = riseEv;
    strb.finish  = lastEv;
    strb.capture = lastEv && !cmdReg[1];
  end

  assign busy    = busyQ;
  assign done    = doneQ;
  assign mdc     = mdcQ;
  assign cmdDir  = cmdReg[1];
  assign cmdWord = cmdReg;

  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busyQ && wrCmd |=> $stable(cmdReg)); // R9
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    startReq |=> busyQ && !doneQ); // R8
  AST_DIV_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (mdcQ != $past(mdcQ)) |-> ($past(divCnt) == CNT_TOP)); // R7
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  mdio_strb_t  strb,
  input  logic [31:0] cmdIn,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        mdioOe,
  output logic [15:0] rdData
);
  localparam int TAIL_BITS = FRAME_BITS - HDR_DRIVEN;

  logic [FRAME_BITS-1:0] frameSr, oeSr, newFrame, newOe;
  logic [DATA_BITS-1:0]  capSr, rdReg;
  logic                  isWrite;
  logic                  unusedCmd;

  assign unusedCmd = ^{cmdIn[31:28], cmdIn[0]};
  assign isWrite   = cmdIn[1];

  always_comb begin
    newFrame = {32'hFFFF_FFFF, 2'b01,
                isWrite ? 2'b01 : 2'b10,
                cmdIn[6:2], cmdIn[11:7],
                isWrite ? 2'b10 : 2'b00,
                isWrite ? cmdIn[27:12] : 16'h0000};
    newOe    = isWrite ? {FRAME_BITS{1'b1}}
                       : {{HDR_DRIVEN{1'b1}}, {TAIL_BITS{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameSr <= '0;
      oeSr    <= '0;
    end else if (strb.load) begin
      frameSr <= newFrame;
      oeSr    <= newOe;
    end else if (strb.finish) begin
      frameSr <= '0;
      oeSr    <= '0;
    end else if (strb.shift) begin
      frameSr <= {frameSr[FRAME_BITS-2:0], 1'b0};
      oeSr    <= {oeSr[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capSr <= '0;
      rdReg <= '0;
    end else begin
      if (strb.sample)  capSr <= {capSr[DATA_BITS-2:0], mdioIn};
      if (strb.capture) rdReg <= capSr;
    end
  end

  assign mdioOut = frameSr[FRAME_BITS-1] & oeSr[FRAME_BITS-1];
  assign mdioOe  = oeSr[FRAME_BITS-1];
  assign rdData  = rdReg;

  AST_LOAD_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> mdioOe && mdioOut); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> $stable(rdReg)); // R10
endmodule

// File: rtl/mdio_master_top.sv
module mdio_master_top
  import mdio_pkg::*;
#(
  parameter int DIV_RATIO = 4,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  mdio_strb_t  strb;
  logic        busy, done, cmdDir;
  logic [27:0] cmdWord;
  logic [15:0] rdData;

  mdio_ctrl #(.DIV_RATIO(DIV_RATIO), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .strb(strb), .busy(busy), .done(done),
    .mdc(mdc), .cmdDir(cmdDir), .cmdWord(cmdWord));

  mdio_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .cmdIn(busWrData),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe), .rdData(rdData));

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_W'(OFS_CMD))         busRdData = {4'h0, cmdWord};
    else if (busAddr == ADDR_W'(OFS_RDDATA)) busRdData = {16'h0, rdData};
    else if (busAddr == ADDR_W'(OFS_STATUS))
      busRdData = {27'h0, done ? 2'b01 : 2'b00, busy ? 3'b001 : 3'b000};
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc && !mdioOe); // R1
  AST_MDIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mdc && $past(mdc) |-> $stable(mdioOut)); // R7
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $fell(mdioOe) |-> !cmdDir); // R5
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [63:0] capFrame = '0, capOe = '0;
  int          fallCnt = 0;
  logic [15:0] respVal = '0;
  bit          respOn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master_top #(.DIV_RATIO(DIV), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn));

  // PHY model: capture on rising mdc, answer after falling mdc
  always @(posedge mdc) begin
    capFrame = {capFrame[62:0], mdioOut};
    capOe    = {capOe[62:0], mdioOe};
  end
  always @(negedge mdc) begin
    fallCnt = fallCnt + 1;
    if (respOn && fallCnt >= 48 && fallCnt <= 63) mdioIn = respVal[63 - fallCnt];
    else mdioIn = 1'b1;
  end

  // dir, phy, reg, data, response
  localparam logic [42:0] VEC [4] = '{
    {1'b1, 5'h01, 5'h00, 16'h1234, 16'h0000},
    {1'b0, 5'h1F, 5'h02, 16'hBEEF, 16'hA5C3},
    {1'b1, 5'h10, 5'h1F, 16'h8001, 16'h0000},
    {1'b0, 5'h05, 5'h15, 16'h0000, 16'h8001}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  function automatic logic [31:0] mkCmd(logic dir, logic [4:0] phy, logic [4:0] rg,
                                        logic [15:0] dat);
    return {4'h0, dat, rg, phy, dir, 1'b1};
  endfunction

  function automatic logic [63:0] expFrame(logic dir, logic [4:0] phy, logic [4:0] rg,
                                           logic [15:0] dat);
    return {32'hFFFF_FFFF, 2'b01, dir ? 2'b01 : 2'b10, phy, rg,
            dir ? 2'b10 : 2'b00, dir ? dat : 16'h0};
  endfunction

  task automatic waitIdle();
    logic [31:0] st;
    for (int i = 0; i < 2000; i++) begin
      busRead(8'h10, st);
      if (st[2:0] == 3'b000) return;
    end
    check("R8 timeout", 64'(st), 64'h8);
  endtask

  task automatic launch(logic dir, logic [4:0] phy, logic [4:0] rg, logic [15:0] dat,
                        logic [15:0] resp);
    fallCnt = 0; respVal = resp; respOn = !dir;
    busWrite(8'h04, mkCmd(dir, phy, rg, dat));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, prevRd;
    logic [63:0] mask;
    longint tRise0, tRise1, tFall;

    repeat (3) @(negedge clk);
    // R1 reset state
    busRead(8'h10, rd); check("R1 status", 64'(rd), 64'h0);
    busRead(8'h0C, rd); check("R1 rddata", 64'(rd), 64'h0);
    check("R1 mdc/oe", {62'h0, mdc, mdioOe}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", {62'h0, mdc, mdioOe}, 64'h0);

    prevRd = 32'h0;
    for (int v = 0; v < 4; v++) begin
      logic dir; logic [4:0] phy, rg; logic [15:0] dat, resp;
      {dir, phy, rg, dat, resp} = VEC[v];
      launch(dir, phy, rg, dat, resp);
      busRead(8'h10, rd); check("R2 busy status", 64'(rd), 64'h1);
      busRead(8'h04, rd); check("R2 cmd readback", 64'(rd), 64'(mkCmd(dir, phy, rg, dat) & ~32'h1));
      waitIdle();
      busRead(8'h10, rd); check("R8 complete", 64'(rd), 64'h8);
      mask = dir ? {64{1'b1}} : {{46{1'b1}}, 18'h0};
      check(dir ? "R4 oe write" : "R5 oe read", capOe, mask);
      check(dir ? "R4 write frame" : "R3 read header", capFrame & mask,
            expFrame(dir, phy, rg, dat) & mask);
      busRead(8'h0C, rd);
      if (dir) check("R10 rddata kept", 64'(rd), 64'(prevRd));
      else begin
        check("R6 read data", 64'(rd), 64'(resp));
        prevRd = rd;
      end
    end

    // R7 mdc period and duty
    launch(1'b1, 5'h03, 5'h04, 16'h5555, 16'h0);
    @(posedge mdc); tRise0 = $time;
    @(negedge mdc); tFall = $time;
    @(posedge mdc); tRise1 = $time;
    check("R7 period", 64'(tRise1 - tRise0), 64'(DIV * CLK_PERIOD));
    check("R7 high half", 64'(tFall - tRise0), 64'(DIV / 2 * CLK_PERIOD));
    // R9 command while busy ignored
    repeat (20) @(negedge clk);
    busWrite(8'h04, mkCmd(1'b0, 5'h1A, 5'h0B, 16'hFFFF));
    busRead(8'h04, rd); check("R9 cmd unchanged", 64'(rd), 64'(mkCmd(1'b1, 5'h03, 5'h04, 16'h5555) & ~32'h1));
    waitIdle();
    check("R9 frame unchanged", capFrame, expFrame(1'b1, 5'h03, 5'h04, 16'h5555));
    repeat (30) @(negedge clk);
    busRead(8'h10, rd); check("R9 no second start", 64'(rd), 64'h8);
    check("R1 idle lines", {62'h0, mdc, mdioOe}, 64'h0);

    // R5 data field ignored on read: line stays quiet in the tail
    launch(1'b0, 5'h07, 5'h09, 16'hFFFF, 16'h0F0F);
    busRead(8'h10, rd); check("R8 complete cleared on start", 64'(rd[4:3]), 64'h0);
    waitIdle();
    check("R5 read ignores data field", capFrame & {{46{1'b1}}, 18'h0},
          expFrame(1'b0, 5'h07, 5'h09, 16'h0) & {{46{1'b1}}, 18'h0});
    check("R5 oe released", capOe, {{46{1'b1}}, 18'h0});
    busRead(8'h0C, rd); check("R6 second read", 64'(rd), 64'h0F0F);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule